// File: doc/BRIEF.md
# Sequential Single-Multiplier FIR Filter

This block is a 31-tap FIR filter that forms each output as the sum of coefficient k times the input taken k samples earlier, for k from 0 to 30. A fully parallel filter would need 31 multipliers. This design uses one multiply-accumulate datapath instead and steps it through every tap, one tap per clock.

A source presents a 16-bit signed sample together with a one-cycle valid strobe. The block writes the sample into a circular history memory. It then runs a sweep: coefficients are read forward from index 0, and stored samples are read backward from the newest one. About 32 clocks later the block presents the low 16 bits of the 32-bit sum with its own one-cycle strobe.

The coefficient set is fixed and symmetric about the centre tap. A new sample may be offered every 33 clocks. Strobes that arrive while a sweep is in progress are dropped.

Top module: `seqfir`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` becomes 0 and `dout_vld` becomes 0. The history memory is cleared at the same edge.
- R2: `dout_vld` is high for exactly one clock per accepted sample.
- R3: A sample accepted at clock edge N produces `dout_vld` high after edge N+32.
- R4: A `din_vld` pulse is accepted only when no sweep is running. A pulse that arrives during edges N+1 to N+32 after an accepted sample at edge N produces no output and does not enter the history. A new sample is accepted at edge N+33.
- R5: `dout` changes only together with a `dout_vld` pulse, and holds its value between results.
- R6: The tap values, in two's complement for index 0 to 15, are FFEF, FFED, FFE8, FFE6, FFEB, 0000, 002C, 0075, 00DC, 015F, 01F4, 028E, 031F, 0394, 03E1, 03FC. Tap 30−k equals tap k. A unit impulse (value 1) followed by zeros therefore yields these values as 31 successive outputs.
- R7: Each output equals bits 15:0 of the exact 32-bit signed sum of coefficient k times sample n−k, for k = 0 to 30.
- R8: The history wraps circularly. After more than 31 samples, only the latest 31 contribute to an output.
- R9: After a reset, outputs are computed as if every earlier sample were zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 16 | Signed input sample |
| din_vld | input | 1 | One-cycle strobe qualifying `din` |
| dout | output | 16 | Low half of the signed tap sum |
| dout_vld | output | 1 | One-cycle strobe qualifying `dout` |

## Verification
Two events can fall in the same clock: the one-cycle result pulse of one sweep, and the acceptance of the next sample that starts a new sweep. The bench provokes this by spacing samples exactly 33 clocks apart, the minimum allowed. The scoreboard then checks both the value and the exact cycle of every result. A second case places stray strobes in the last busy cycle and in the middle of a sweep. These must produce neither an extra result nor any change to later outputs.

// File: rtl/seqfir.sv
module seqfir #(
  parameter int W    = 16,
  parameter int TAPS = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] din,
  input  logic                din_vld,
  output logic signed [W-1:0] dout,
  output logic                dout_vld
);
  localparam int AW   = $clog2(TAPS);
  localparam int ACCW = 2 * W;

  typedef enum logic [1:0] {IDLE, RUN, DRAIN} st_t;

  function automatic logic signed [W-1:0] coef(input int k);
    int m;
    m = (k > TAPS / 2) ? TAPS - 1 - k : k;
    case (m)
      0:  coef = W'(16'hFFEF);
      1:  coef = W'(16'hFFED);
      2:  coef = W'(16'hFFE8);
      3:  coef = W'(16'hFFE6);
      4:  coef = W'(16'hFFEB);
      5:  coef = W'(16'h0000);
      6:  coef = W'(16'h002C);
      7:  coef = W'(16'h0075);
      8:  coef = W'(16'h00DC);
      9:  coef = W'(16'h015F);
      10: coef = W'(16'h01F4);
      11: coef = W'(16'h028E);
      12: coef = W'(16'h031F);
      13: coef = W'(16'h0394);
      14: coef = W'(16'h03E1);
      15: coef = W'(16'h03FC);
      default: coef = '0;
    endcase
  endfunction

  st_t                   st;
  logic signed [W-1:0]   smem [TAPS];
  logic [AW-1:0]         wp, rp, k;
  logic signed [W-1:0]   creg, sreg;
  logic signed [ACCW-1:0] acc, prod, sum;

  assign prod = ACCW'(creg) * ACCW'(sreg);
  assign sum  = acc + prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= IDLE;
      wp       <= '0;
      rp       <= '0;
      k        <= '0;
      creg     <= '0;
      sreg     <= '0;
      acc      <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
      for (int i = 0; i < TAPS; i++) smem[i] <= '0;
    end else begin
      dout_vld <= 1'b0;
      case (st)
        IDLE: if (din_vld) begin
          smem[wp] <= din;
          rp       <= wp;
          k        <= '0;
          acc      <= '0;
          creg     <= '0;
          sreg     <= '0;
          st       <= RUN;
        end
        RUN: begin
          creg <= coef(int'(k));
          sreg <= smem[rp];
          acc  <= sum;
          rp   <= (rp == '0) ? AW'(TAPS - 1) : rp - AW'(1);
          k    <= k + AW'(1);
          if (k == AW'(TAPS - 1)) st <= DRAIN;
        end
        DRAIN: begin
          dout     <= sum[W-1:0];
          dout_vld <= 1'b1;
          wp       <= (wp == AW'(TAPS - 1)) ? '0 : wp + AW'(1);
          st       <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_rst_quiet_r1: assert property (@(posedge clk) rst |=> (!dout_vld && dout == '0));
  p_pulse_one_r2: assert property (@(posedge clk) disable iff (rst) dout_vld |=> !dout_vld);
  p_after_sweep_r3: assert property (@(posedge clk) disable iff (rst) dout_vld |-> $past(st) == DRAIN);
  p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst) (st == RUN) |=> $stable(wp));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst) !dout_vld |-> $stable(dout));
  p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst) (wp < AW'(TAPS) && rp < AW'(TAPS)));
endmodule

// File: tb/seqfir_test.sv
module seqfir_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] din = '0;
  logic din_vld = 1'b0;
  logic signed [15:0] dout;
  logic dout_vld;

  seqfir uut (.clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .dout(dout), .dout_vld(dout_vld));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;
  int qv[$];
  int qt[$];
  int hist[31];
  logic signed [15:0] last_out = '0;

  const logic signed [15:0] cf[31] = '{
    16'hFFEF, 16'hFFED, 16'hFFE8, 16'hFFE6, 16'hFFEB, 16'h0000, 16'h002C, 16'h0075,
    16'h00DC, 16'h015F, 16'h01F4, 16'h028E, 16'h031F, 16'h0394, 16'h03E1, 16'h03FC,
    16'h03E1, 16'h0394, 16'h031F, 16'h028E, 16'h01F4, 16'h015F, 16'h00DC, 16'h0075,
    16'h002C, 16'h0000, 16'hFFEB, 16'hFFE6, 16'hFFE8, 16'hFFED, 16'hFFEF};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 31; i++) hist[i] = 0;
  endtask

  // Drive one sample; stray strobes at offsets s1/s2 (0 = none) inside the gap.
  task automatic send(input logic signed [15:0] x, input int gap, input int s1, input int s2);
    longint acc;
    logic signed [15:0] y;
    for (int i = 30; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    acc = 0;
    for (int i = 0; i < 31; i++) acc += longint'(cf[i]) * longint'(hist[i]);
    y = acc[15:0];
    qv.push_back(int'(y));
    qt.push_back(cyc + 33);
    din = x; din_vld = 1'b1;
    @(negedge clk);
    din_vld = 1'b0; din = '0;
    for (int g = 1; g < gap; g++) begin
      if (g == s1 || g == s2) begin din = 16'sh7FFF; din_vld = 1'b1; end
      @(negedge clk);
      din_vld = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (dout_vld) begin
        if (qv.size() == 0) begin
          check(1'b0, "R4 unexpected output", int'(dout), 0);
        end else begin
          int ev, et;
          ev = qv.pop_front();
          et = qt.pop_front();
          check(int'(dout) == ev, "R7 value", int'(dout), ev);
          check(cyc == et, "R3 timing", cyc, et);
        end
        last_out = dout;
      end else if (cyc > 2) begin
        if (dout != last_out) check(1'b0, "R5 hold", int'(dout), int'(last_out));
      end
    end
  end

  logic prev_vld = 1'b0;
  always @(negedge clk) begin
    if (!rst && prev_vld && dout_vld) check(1'b0, "R2 pulse width", 1, 0);
    prev_vld = dout_vld;
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dout == 0, "R1 dout reset", int'(dout), 0);
    check(dout_vld == 0, "R1 dout_vld reset", int'(dout_vld), 0);
    qv.delete(); qt.delete(); clear_hist();
    last_out = '0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    clear_hist();
    @(negedge clk);
    do_reset();
    // R6 impulse response at minimum spacing (result pulse coincides with next acceptance)
    begin
      send(16'sd1, 33, 0, 0);
      for (int i = 1; i < 31; i++) send(16'sd0, 33, 0, 0);
    end
    repeat (40) @(negedge clk);
    check(qv.size() == 0, "R6 impulse outputs all seen", qv.size(), 0);
    // R7/R8 random stream, over two wraps, with stray strobes (R4)
    for (int i = 0; i < 70; i++) begin
      logic signed [15:0] r;
      r = 16'($urandom);
      if (i % 7 == 3) send(r, 33, 5, 32);
      else send(r, (i % 3 == 0) ? 40 : 33, 0, 0);
    end
    repeat (40) @(negedge clk);
    check(qv.size() == 0, "R4 R8 all outputs seen, none extra", qv.size(), 0);
    // R9 reset mid-history, then outputs follow a zero past
    do_reset();
    send(16'sd100, 33, 0, 0);
    send(-16'sd3000, 33, 0, 0);
    send(16'sd32767, 33, 0, 0);
    repeat (40) @(negedge clk);
    check(qv.size() == 0, "R9 outputs after reset seen", qv.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // R6 direct check of impulse values is covered by R7 model using the tap list
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule